// File: doc/BRIEF.md
# MSI-X Vector Unit

This block holds the MSI-X capability of a PCIe function together with the vector table that software maps through a BAR. A configuration port returns the three capability dwords: the header with the control word, the table locator and the pending-array locator. A table port gives 32-bit access to per-vector entries of 16 bytes each. Each entry holds a 64-bit message address, 32-bit message data and a mask bit.

Device logic raises one request line per vector. A request is accepted only if the vector can be delivered at that moment. Accepted requests turn into message writes on a valid/ready output, one at a time. When several requests are accepted at once, the lowest-numbered vector is served first. A request that arrives while its vector is blocked is discarded and is not replayed later.

Top module: `msix_vector_unit`

## Requirements
- R1: A read of the capability at byte offset 0 returns dword {enable[31], function mask[30], 3'b0, NVEC-1 in [26:16], NEXT_PTR in [15:8], 8'h11 in [7:0]}.
- R2: Only a write with size 2 at offset 2 changes the control word: bit 15 of the halfword (cfg_wdata[15]) sets enable, bit 14 sets function mask. Every other capability write, and every other bit, has no effect.
- R3: Offset 4 reads {TBL_OFFSET[31:3], TBL_BIR}. Offset 8 reads {PBA_OFFSET[31:3], PBA_BIR}. Offset 12 and above read 0.
- R4: In the table, vector i sits at byte 16*i. Word +0 is address low, +4 is address high, +8 is data and +12 is vector control. A read of vector control returns only the mask in bit 0.
- R5: A table access whose size is not 4, or whose address is not 4-byte aligned, changes nothing and reads 0.
- R6: A table access whose vector index (address bits above 3) is NVEC or more changes nothing and reads 0.
- R7: After reset every entry has address and data equal to 0 and mask equal to 1. Enable and function mask are 0, and no message is valid.
- R8: tbl_mask_chg pulses for one cycle after a vector-control write that flips the mask. A write that leaves the mask unchanged gives no pulse.
- R9: A request is accepted only while enable=1, function mask=0 and the entry mask=0. Otherwise it is dropped, and no message is produced for it later.
- R10: A message carries {address high, address low} and data as they stood when it was issued. These values stay stable while msg_valid=1 and msg_ready=0.
- R11: Accepted vectors are issued lowest index first, one message at a time. After each handshake msg_valid is low for one cycle.
- R12: An accepted but not yet issued request is discarded if its vector stops being deliverable before it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 4 | Byte offset within the capability |
| cfg_size | input | 3 | Access size in bytes |
| cfg_wr | input | 1 | Capability write strobe |
| cfg_wdata | input | 32 | Write data, right-justified |
| cfg_rdata | output | 32 | Dword at cfg_addr[3:2] |
| tbl_req | input | 1 | Table access strobe |
| tbl_we | input | 1 | 1 = write, 0 = read |
| tbl_addr | input | TA_W | Byte address within the table window |
| tbl_size | input | 3 | Access size in bytes |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data (0 when not a valid read) |
| tbl_mask_chg | output | 1 | Mask of some entry flipped on the last write |
| vec_req | input | NVEC | Per-vector request pulses |
| msg_valid | output | 1 | Message write is presented |
| msg_ready | input | 1 | Sink accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest situation to reach is a vector that is accepted but waiting, because an earlier message is stalled, and that is then masked before its turn comes. The stimulus holds msg_ready low and raises two requests in the same cycle. It masks the second entry through the table port while the first message is stalled, then releases ready and expects exactly one message. A related check raises a request against a masked entry, unmasks it afterwards and confirms that no message appears.

// File: rtl/msixv_pkg.sv
package msixv_pkg;
    localparam logic [7:0] CAP_ID = 8'h11;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;
endpackage

// File: rtl/msixv_cap_regs.sv
module msixv_cap_regs #(
    parameter int          NVEC       = 8,
    parameter logic [7:0]  NEXT_PTR   = 8'h00,
    parameter logic [31:0] TBL_OFFSET = 32'h0000_2000,
    parameter logic [2:0]  TBL_BIR    = 3'd2,
    parameter logic [31:0] PBA_OFFSET = 32'h0000_3000,
    parameter logic [2:0]  PBA_BIR    = 3'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  cfg_addr,
    input  logic [2:0]  cfg_size,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        en_o,
    output logic        fmask_o
);
    localparam logic [10:0] TSIZE = 11'(NVEC - 1);

    typedef struct packed {
        logic en;
        logic fm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic ctl_hit;
    logic unused_ok;

    assign ctl_hit   = cfg_wr && (cfg_addr == 4'd2) && (cfg_size == 3'd2);
    assign unused_ok = ^{cfg_wdata[31:16], cfg_wdata[13:0]};

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_hit) begin
            ctl_d.en = cfg_wdata[15];
            ctl_d.fm = cfg_wdata[14];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (cfg_addr[3:2])
            2'd0:    cfg_rdata = {ctl_q.en, ctl_q.fm, 3'b000, TSIZE, NEXT_PTR, msixv_pkg::CAP_ID};
            2'd1:    cfg_rdata = {TBL_OFFSET[31:3], TBL_BIR};
            2'd2:    cfg_rdata = {PBA_OFFSET[31:3], PBA_BIR};
            default: cfg_rdata = '0;
        endcase
    end

    assign en_o    = ctl_q.en;
    assign fmask_o = ctl_q.fm;

    // R2: writes other than the halfword at offset 2 leave the control bits alone
    assert_ctl_write_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !(cfg_addr == 4'd2 && cfg_size == 3'd2)) |=> ($stable(en_o) && $stable(fmask_o)));
endmodule

// File: rtl/msixv_table.sv
module msixv_table #(
    parameter int NVEC = 8,
    parameter int TA_W = 12
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    tbl_req,
    input  logic                                    tbl_we,
    input  logic [TA_W-1:0]                         tbl_addr,
    input  logic [2:0]                              tbl_size,
    input  logic [31:0]                             tbl_wdata,
    output logic [31:0]                             tbl_rdata,
    output logic                                    tbl_mask_chg,
    output msixv_pkg::vec_entry_t [NVEC-1:0]        ent_o
);
    import msixv_pkg::*;

    localparam int IDX_W = TA_W - 4;
    localparam int SEL_W = (NVEC > 1) ? $clog2(NVEC) : 1;

    typedef struct packed {
        vec_entry_t [NVEC-1:0] ent;
        logic                  chg;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic             aligned, hit;
    logic [NVEC-1:0]  mask_vec;

    assign idx     = tbl_addr[TA_W-1:4];
    assign sel     = idx[SEL_W-1:0];
    assign aligned = (tbl_size == 3'd4) && (tbl_addr[1:0] == 2'b00);
    assign hit     = tbl_req && aligned && ({1'b0, idx} < (IDX_W+1)'(NVEC));

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (hit && tbl_we) begin
            unique case (tbl_addr[3:2])
                2'd0: st_d.ent[sel].lo   = tbl_wdata;
                2'd1: st_d.ent[sel].hi   = tbl_wdata;
                2'd2: st_d.ent[sel].data = tbl_wdata;
                default: begin
                    st_d.ent[sel].mask = tbl_wdata[0];
                    st_d.chg           = (tbl_wdata[0] != st_q.ent[sel].mask);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVEC; i++) begin
                st_q.ent[i] <= '{lo: '0, hi: '0, data: '0, mask: 1'b1};
            end
            st_q.chg <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tbl_rdata = '0;
        if (hit && !tbl_we) begin
            unique case (tbl_addr[3:2])
                2'd0:    tbl_rdata = st_q.ent[sel].lo;
                2'd1:    tbl_rdata = st_q.ent[sel].hi;
                2'd2:    tbl_rdata = st_q.ent[sel].data;
                default: tbl_rdata = {31'b0, st_q.ent[sel].mask};
            endcase
        end
    end

    for (genvar g = 0; g < NVEC; g++) begin : g_mask
        assign mask_vec[g] = st_q.ent[g].mask;
    end

    assign ent_o        = st_q.ent;
    assign tbl_mask_chg = st_q.chg;

    // R5: a misaligned or wrong-size write leaves every entry unchanged
    assert_misaligned_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && tbl_we && !aligned) |=> $stable(ent_o));

    // R8: a change pulse always coincides with a real flip of some mask
    assert_mask_chg_real_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbl_mask_chg) |-> (mask_vec != $past(mask_vec)));
endmodule

// File: rtl/msixv_issue.sv
module msixv_issue #(
    parameter int NVEC = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en_i,
    input  logic                              fmask_i,
    input  msixv_pkg::vec_entry_t [NVEC-1:0]  ent_i,
    input  logic [NVEC-1:0]                   vec_req,
    output logic                              msg_valid,
    input  logic                              msg_ready,
    output logic [63:0]                       msg_addr,
    output logic [31:0]                       msg_data
);
    localparam int SEL_W = (NVEC > 1) ? $clog2(NVEC) : 1;

    typedef struct packed {
        logic            valid;
        logic [63:0]     addr;
        logic [31:0]     data;
        logic [NVEC-1:0] pend;
    } iss_t;

    iss_t iss_d, iss_q;
    logic [NVEC-1:0]  dlv, cand;
    logic [SEL_W-1:0] sel;

    for (genvar g = 0; g < NVEC; g++) begin : g_dlv
        assign dlv[g] = en_i && !fmask_i && !ent_i[g].mask;
    end

    assign cand = (iss_q.pend | vec_req) & dlv;

    always_comb begin
        sel = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (cand[i]) sel = SEL_W'(i);
        end
    end

    always_comb begin
        iss_d      = iss_q;
        iss_d.pend = cand;
        if (!iss_q.valid && (|cand)) begin
            iss_d.valid     = 1'b1;
            iss_d.addr      = {ent_i[sel].hi, ent_i[sel].lo};
            iss_d.data      = ent_i[sel].data;
            iss_d.pend[sel] = 1'b0;
        end else if (iss_q.valid && msg_ready) begin
            iss_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign msg_valid = iss_q.valid;
    assign msg_addr  = iss_q.addr;
    assign msg_data  = iss_q.data;

    // R10: a stalled message holds its contents
    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R11: valid drops for one cycle after each handshake
    assert_gap_after_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    // R9: a new message only appears while the function is enabled and unmasked
    assert_issue_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(en_i && !fmask_i));
endmodule

// File: rtl/msix_vector_unit.sv
module msix_vector_unit #(
    parameter int          NVEC       = 8,
    parameter int          TA_W       = 12,
    parameter logic [7:0]  NEXT_PTR   = 8'h00,
    parameter logic [31:0] TBL_OFFSET = 32'h0000_2000,
    parameter logic [2:0]  TBL_BIR    = 3'd2,
    parameter logic [31:0] PBA_OFFSET = 32'h0000_3000,
    parameter logic [2:0]  PBA_BIR    = 3'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_addr,
    input  logic [2:0]       cfg_size,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             tbl_req,
    input  logic             tbl_we,
    input  logic [TA_W-1:0]  tbl_addr,
    input  logic [2:0]       tbl_size,
    input  logic [31:0]      tbl_wdata,
    output logic [31:0]      tbl_rdata,
    output logic             tbl_mask_chg,
    input  logic [NVEC-1:0]  vec_req,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    logic en, fmask;
    msixv_pkg::vec_entry_t [NVEC-1:0] ent;

    msixv_cap_regs #(
        .NVEC(NVEC), .NEXT_PTR(NEXT_PTR),
        .TBL_OFFSET(TBL_OFFSET), .TBL_BIR(TBL_BIR),
        .PBA_OFFSET(PBA_OFFSET), .PBA_BIR(PBA_BIR)
    ) u_cap (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .en_o(en), .fmask_o(fmask)
    );

    msixv_table #(.NVEC(NVEC), .TA_W(TA_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_size(tbl_size), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .tbl_mask_chg(tbl_mask_chg), .ent_o(ent)
    );

    msixv_issue #(.NVEC(NVEC)) u_iss (
        .clk(clk), .rst_n(rst_n),
        .en_i(en), .fmask_i(fmask), .ent_i(ent), .vec_req(vec_req),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );
endmodule

// File: tb/msix_vector_unit_tb.sv
module msix_vector_unit_tb;
    localparam int NVEC = 8;
    localparam int TA_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [2:0]  cfg_size = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tbl_req = 1'b0, tbl_we = 1'b0;
    logic [TA_W-1:0] tbl_addr = '0;
    logic [2:0]  tbl_size = '0;
    logic [31:0] tbl_wdata = '0, tbl_rdata;
    logic        tbl_mask_chg;
    logic [NVEC-1:0] vec_req = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    always #2 clk = ~clk;

    msix_vector_unit #(.NVEC(NVEC), .TA_W(TA_W)) u_dut (.*);

    int checks = 0, fails = 0;
    logic [95:0] exp_q[$];
    int ready_mode = 0;
    logic tog = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always begin
        @(posedge clk);
        #1;
        tog = ~tog;
        msg_ready = (ready_mode == 1) || (ready_mode == 2 && tog);
    end

    // monitor: scoreboard pop on each handshake, stall stability
    logic [95:0] prev_msg;
    bit prev_stall = 1'b0;
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (prev_stall)
                check({msg_addr, msg_data} == prev_msg, "R10 stall hold", {msg_addr, msg_data}, prev_msg);
            if (msg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9/R12 unexpected message", {msg_addr, msg_data}, '0);
                end else begin
                    automatic logic [95:0] e = exp_q.pop_front();
                    check({msg_addr, msg_data} == e, "R11 message order/content", {msg_addr, msg_data}, e);
                end
            end
            prev_stall = !msg_ready;
            prev_msg = {msg_addr, msg_data};
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic cfg_write(input logic [3:0] a, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_size = s; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic tbl_write(input logic [TA_W-1:0] a, input logic [2:0] s, input logic [31:0] d, output logic chg);
        @(negedge clk);
        tbl_req = 1'b1; tbl_we = 1'b1; tbl_addr = a; tbl_size = s; tbl_wdata = d;
        @(negedge clk);
        chg = tbl_mask_chg;
        tbl_req = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic tbl_read(input logic [TA_W-1:0] a, input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        tbl_req = 1'b1; tbl_we = 1'b0; tbl_addr = a; tbl_size = s;
        #1 d = tbl_rdata;
        @(negedge clk);
        tbl_req = 1'b0;
    endtask

    task automatic set_entry(input int v, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] dt, input logic m);
        logic c;
        tbl_write(TA_W'(v * 16 + 0), 3'd4, lo, c);
        tbl_write(TA_W'(v * 16 + 4), 3'd4, hi, c);
        tbl_write(TA_W'(v * 16 + 8), 3'd4, dt, c);
        tbl_write(TA_W'(v * 16 + 12), 3'd4, {31'b0, m}, c);
    endtask

    task automatic pulse(input logic [NVEC-1:0] r);
        @(negedge clk);
        vec_req = r;
        @(negedge clk);
        vec_req = '0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0 && !msg_valid, req, 96'(exp_q.size()), '0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            check(1'b0, "watchdog", '0, '0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 / R1 reset state
        cfg_read(4'd0, d);  check(d == 32'h0007_0011, "R1 R7 header after reset", d, 32'h0007_0011);
        tbl_read(12'h01C, 3'd4, d); check(d == 32'h1, "R7 entry mask set", d, 1);
        tbl_read(12'h010, 3'd4, d); check(d == 32'h0, "R7 entry address clear", d, 0);
        check(!msg_valid, "R7 no message after reset", msg_valid, 0);

        // R3 locators
        cfg_read(4'd4, d);  check(d == 32'h0000_2002, "R3 table locator", d, 32'h2002);
        cfg_read(4'd8, d);  check(d == 32'h0000_3002, "R3 pba locator", d, 32'h3002);
        cfg_read(4'd12, d); check(d == 32'h0, "R3 beyond capability", d, 0);

        // R2 write filtering
        cfg_write(4'd0, 3'd4, 32'hFFFF_FFFF);
        cfg_read(4'd0, d);  check(d == 32'h0007_0011, "R2 dword write ignored", d, 32'h0007_0011);
        cfg_write(4'd2, 3'd4, 32'h0000_C000);
        cfg_read(4'd0, d);  check(d == 32'h0007_0011, "R2 wrong size ignored", d, 32'h0007_0011);
        cfg_write(4'd2, 3'd2, 32'h0000_FFFF);
        cfg_read(4'd0, d);  check(d == 32'hC007_0011, "R2 enable and mask set", d, 32'hC007_0011);
        cfg_write(4'd2, 3'd2, 32'h0000_8000);
        cfg_read(4'd0, d);  check(d == 32'h8007_0011, "R2 function mask cleared", d, 32'h8007_0011);

        // R4 layout and R8 change pulse
        set_entry(3, 32'hA000_0030, 32'h0000_00B3, 32'h0000_0333, 1'b1);
        tbl_read(12'h030, 3'd4, d); check(d == 32'hA000_0030, "R4 address low", d, 32'hA000_0030);
        tbl_read(12'h034, 3'd4, d); check(d == 32'h0000_00B3, "R4 address high", d, 32'hB3);
        tbl_read(12'h038, 3'd4, d); check(d == 32'h0000_0333, "R4 data", d, 32'h333);
        tbl_write(12'h03C, 3'd4, 32'hFFFF_FFFE, c);
        check(c == 1'b1, "R8 pulse on mask flip", c, 1);
        tbl_read(12'h03C, 3'd4, d); check(d == 32'h0, "R4 control reads only mask", d, 0);
        tbl_write(12'h03C, 3'd4, 32'h0, c);
        check(c == 1'b0, "R8 no pulse without flip", c, 0);

        // R5 misaligned / wrong size
        tbl_write(12'h030, 3'd2, 32'h1111_1111, c);
        tbl_write(12'h032, 3'd4, 32'h2222_2222, c);
        tbl_read(12'h030, 3'd4, d); check(d == 32'hA000_0030, "R5 bad writes ignored", d, 32'hA000_0030);
        tbl_read(12'h030, 3'd2, d); check(d == 32'h0, "R5 wrong size read zero", d, 0);
        tbl_read(12'h031, 3'd4, d); check(d == 32'h0, "R5 misaligned read zero", d, 0);

        // R6 out of range
        tbl_write(12'h080, 3'd4, 32'h5555_5555, c);
        tbl_read(12'h000, 3'd4, d); check(d == 32'h0, "R6 no alias into entry 0", d, 0);
        tbl_read(12'h080, 3'd4, d); check(d == 32'h0, "R6 out of range read zero", d, 0);

        // R9 delivery gating
        ready_mode = 1;
        exp_q.push_back({32'h0000_00B3, 32'hA000_0030, 32'h0000_0333});
        pulse(8'b0000_1000);
        drain("R9 deliverable vector sent");
        pulse(8'b0000_0100);
        set_entry(2, 32'h2, 32'h0, 32'h22, 1'b0);
        drain("R9 masked request dropped");
        cfg_write(4'd2, 3'd2, 32'h0000_C000);
        pulse(8'b0000_1000);
        cfg_write(4'd2, 3'd2, 32'h0000_8000);
        drain("R9 function mask blocks");

        // R11 priority with a toggling ready, R10 hold
        set_entry(1, 32'h1, 32'h10, 32'h11, 1'b0);
        set_entry(5, 32'h5, 32'h50, 32'h55, 1'b0);
        ready_mode = 2;
        exp_q.push_back({32'h10, 32'h1, 32'h11});
        exp_q.push_back({32'hB3, 32'hA000_0030, 32'h333});
        exp_q.push_back({32'h50, 32'h5, 32'h55});
        pulse(8'b0010_1010);
        drain("R11 lowest index first");

        // R12 pending discarded when masked
        ready_mode = 0;
        exp_q.push_back({32'h10, 32'h1, 32'h11});
        pulse(8'b0000_1010);
        tbl_write(12'h03C, 3'd4, 32'h1, c);
        ready_mode = 1;
        drain("R12 pending vector discarded");

        // R7 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        tbl_read(12'h010, 3'd4, d); check(d == 32'h0, "R7 reset clears entry", d, 0);
        tbl_read(12'h01C, 3'd4, d); check(d == 32'h1, "R7 reset masks entry", d, 1);
        cfg_read(4'd0, d); check(d == 32'h0007_0011, "R7 reset clears control", d, 32'h0007_0011);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule